// File: doc/BRIEF.md
# Omega Network Destination-Tag Router

This block connects N sources to N destinations through an omega network. The network has log2(N) stages of N/2 two-by-two switches. A perfect-shuffle wiring comes before each stage, and it moves line i to the line whose index is i rotated left by one bit. A source raises `req_valid` with a destination tag and a data word. Each stage steers the request with one tag bit, starting from the most significant bit. Every source–destination pair has exactly one path. Some sets of requests therefore cannot be served together, and a request that loses at a switch is flagged as blocked.

Each source is tracked by a small state machine with three states: `ST_IDLE`, `ST_HOLD` and `ST_DENIED`. The first cycle in which `req_valid` is high on an idle source is the setup pass. It takes one of two transitions:
- **setup-won** to `ST_HOLD`, when the request reaches its destination;
- **setup-lost** to `ST_DENIED`, when the request is dropped at a switch.

A source in `ST_HOLD` keeps its path locked, and its data word flows to the destination over that path. Lowering `req_valid` takes one of two transitions back to `ST_IDLE`:
- **release** from `ST_HOLD`;
- **withdraw** from `ST_DENIED`.

There are no retries: a denied source must drop `req_valid` before it can try again.

Top module: `omega_router`

## Requirements
- R1: When an idle source raises `req_valid` with tag d and meets no conflict, then on the next clock edge `src_granted[s]`, `dst_valid[d]` and `dst_src[d]=s` all become high or valid. This holds for every source and every destination.
- R2: Stages are numbered k = 1 to log2(N).
  - Stage k examines tag bit log2(N)-k. A value of 0 selects the upper (even) switch output and a value of 1 selects the lower (odd) output.
  - After stage k, the request from source s to destination d occupies line ((s << k) mod N) | (d >> (log2(N)-k)).
  - Two requests interfere only when they meet on the same line after the same stage.
- R3: When two new requests at one switch want the same output, the request on the upper input wins. The upper input is the even shuffled line. The lower request is denied. Example: sources 0 and 4, both aimed at destinations 4 to 7, give source 0 granted and source 4 blocked.
- R4: A denied source has `src_blocked` high from the cycle after its request. It stays high while `req_valid` stays high, even after the conflict has gone away. It is never high together with `src_granted`, and it drives no destination.
- R5: While a granted source keeps `req_valid` high, the path stays connected. `dst_data[d]` follows the source's current `req_data` in the same cycle. Changes to the source's `req_dest` during this time are ignored.
- R6: A switch output used by a locked path cannot be taken by a new request, even one arriving on the upper input. That new request is denied.
- R7: One edge after a source lowers `req_valid`, its `src_granted` and `src_blocked` are low and its destination's `dst_valid` is low. A later request from that source is arbitrated afresh.
- R8: Each destination is driven by at most one source. The count of granted sources equals the count of valid destinations.
- R9: During and straight after reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | N | Request valid per source |
| req_dest | input | N*log2(N) | Destination tag per source, source s at bits s*log2(N) upward |
| req_data | input | N*DW | Data word per source |
| src_granted | output | N | Source holds a connected path |
| src_blocked | output | N | Source request was denied |
| dst_valid | output | N | Destination is connected |
| dst_src | output | N*log2(N) | Index of the source connected to each destination |
| dst_data | output | N*DW | Data delivered to each destination |

## Verification
The bench uses the default build: LOG2N=3, which gives eight sources, eight destinations and three stages, and DW=8.

At this size several sweeps are practical:
- all 64 source–destination pairs, each run alone;
- every two-source combination of destinations (1792 cases), compared against an arithmetic per-stage line model;
- a long run of random full-load traffic, with paths locking and releasing.

Together these reach every switch output at every stage, every arbitration tie, and every lock conflict.

// File: rtl/omega_pkg.sv
`timescale 1ns/1ps
package omega_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_HOLD   = 2'd1,
        ST_DENIED = 2'd2
    } src_state_e;

    // Perfect shuffle: rotate a w-bit line index left by one.
    function automatic int shuffle_line(input int v, input int w);
        int mask;
        mask = (1 << w) - 1;
        return ((v << 1) | (v >> (w - 1))) & mask;
    endfunction

    // Line occupied after stage k (0-based) by the path from s to d.
    function automatic int path_line(input int s, input int d, input int k, input int w);
        int mask;
        mask = (1 << w) - 1;
        return ((s << (k + 1)) & mask) | (d >> (w - 1 - k));
    endfunction

endpackage

// File: rtl/omega_switch.sv
`timescale 1ns/1ps
module omega_switch (
    input  logic       up_vld,
    input  logic       up_bit,
    input  logic       lo_vld,
    input  logic       lo_bit,
    input  logic [1:0] busy,
    output logic [1:0] take_up,
    output logic [1:0] take_lo
);
    logic [1:0] want_up;
    logic [1:0] want_lo;

    always_comb begin
        want_up[0] = up_vld && !up_bit;
        want_up[1] = up_vld &&  up_bit;
        want_lo[0] = lo_vld && !lo_bit;
        want_lo[1] = lo_vld &&  lo_bit;
        // Locked paths own their ports; upper input wins a tie.
        take_up = want_up & ~busy;
        take_lo = want_lo & ~busy & ~want_up;
    end
endmodule

// File: rtl/omega_stage.sv
`timescale 1ns/1ps
module omega_stage #(
    parameter int L = 3,
    parameter int K = 0
) (
    input  logic [(1<<L)-1:0]     in_vld,
    input  logic [(1<<L)*L-1:0]   in_src,
    input  logic [(1<<L)*L-1:0]   in_tag,
    input  logic [(1<<L)-1:0]     busy,
    output logic [(1<<L)-1:0]     out_vld,
    output logic [(1<<L)*L-1:0]   out_src,
    output logic [(1<<L)*L-1:0]   out_tag
);
    import omega_pkg::*;
    localparam int N    = 1 << L;
    localparam int SW   = N / 2;
    localparam int TBIT = L - 1 - K;

    logic [N-1:0]   sh_vld;
    logic [N*L-1:0] sh_src;
    logic [N*L-1:0] sh_tag;

    for (genvar i = 0; i < N; i++) begin : g_shuffle
        localparam int J = shuffle_line(i, L);
        assign sh_vld[J]         = in_vld[i];
        assign sh_src[J*L +: L]  = in_src[i*L +: L];
        assign sh_tag[J*L +: L]  = in_tag[i*L +: L];
    end

    for (genvar w = 0; w < SW; w++) begin : g_sw
        logic [1:0] take_up;
        logic [1:0] take_lo;

        omega_switch u_sw (
            .up_vld  (sh_vld[2*w]),
            .up_bit  (sh_tag[(2*w)*L + TBIT]),
            .lo_vld  (sh_vld[2*w+1]),
            .lo_bit  (sh_tag[(2*w+1)*L + TBIT]),
            .busy    (busy[2*w +: 2]),
            .take_up (take_up),
            .take_lo (take_lo)
        );

        for (genvar o = 0; o < 2; o++) begin : g_out
            assign out_vld[2*w+o] = take_up[o] | take_lo[o];
            assign out_src[(2*w+o)*L +: L] = take_lo[o] ? sh_src[(2*w+1)*L +: L]
                                                        : sh_src[(2*w)*L +: L];
            assign out_tag[(2*w+o)*L +: L] = take_lo[o] ? sh_tag[(2*w+1)*L +: L]
                                                        : sh_tag[(2*w)*L +: L];
        end
    end
endmodule

// File: rtl/omega_occupancy.sv
`timescale 1ns/1ps
module omega_occupancy #(
    parameter int L = 3
) (
    input  logic [(1<<L)-1:0]     hold,
    input  logic [(1<<L)*L-1:0]   held_dest,
    output logic [L*(1<<L)-1:0]   busy
);
    import omega_pkg::*;
    localparam int N = 1 << L;

    always_comb begin
        busy = '0;
        for (int k = 0; k < L; k++) begin
            for (int ln = 0; ln < N; ln++) begin
                for (int s = 0; s < N; s++) begin
                    if (hold[s] && path_line(s, int'(held_dest[s*L +: L]), k, L) == ln)
                        busy[k*N + ln] = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/omega_src_fsm.sv
`timescale 1ns/1ps
module omega_src_fsm #(
    parameter int L = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req_valid,
    input  logic [L-1:0] req_dest,
    input  logic         win,
    output logic         trying,
    output logic         hold,
    output logic         denied,
    output logic [L-1:0] held_dest
);
    import omega_pkg::*;

    src_state_e state;
    src_state_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            held_dest <= '0;
        else if (state == ST_IDLE && req_valid && win)
            held_dest <= req_dest;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (req_valid) nxt = win ? ST_HOLD : ST_DENIED;
            ST_HOLD:   if (!req_valid) nxt = ST_IDLE;
            ST_DENIED: if (!req_valid) nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        trying = 1'b0;
        hold   = 1'b0;
        denied = 1'b0;
        unique case (state)
            ST_IDLE:   trying = req_valid;
            ST_HOLD:   hold   = 1'b1;
            ST_DENIED: denied = 1'b1;
            default:   ;
        endcase
    end
endmodule

// File: rtl/omega_router.sv
`timescale 1ns/1ps
module omega_router #(
    parameter int LOG2N = 3,
    parameter int DW    = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [(1<<LOG2N)-1:0]       req_valid,
    input  logic [(1<<LOG2N)*LOG2N-1:0] req_dest,
    input  logic [(1<<LOG2N)*DW-1:0]    req_data,
    output logic [(1<<LOG2N)-1:0]       src_granted,
    output logic [(1<<LOG2N)-1:0]       src_blocked,
    output logic [(1<<LOG2N)-1:0]       dst_valid,
    output logic [(1<<LOG2N)*LOG2N-1:0] dst_src,
    output logic [(1<<LOG2N)*DW-1:0]    dst_data
);
    localparam int L = LOG2N;
    localparam int N = 1 << L;

    logic [N-1:0]   trying;
    logic [N-1:0]   hold;
    logic [N-1:0]   denied;
    logic [N-1:0]   win;
    logic [N*L-1:0] held_dest;
    logic [L*N-1:0] busy;

    logic [N-1:0]   ln_vld [L+1];
    logic [N*L-1:0] ln_src [L+1];
    logic [N*L-1:0] ln_tag [L+1];

    for (genvar s = 0; s < N; s++) begin : g_src
        omega_src_fsm #(.L(L)) u_fsm (
            .clk       (clk),
            .rst_n     (rst_n),
            .req_valid (req_valid[s]),
            .req_dest  (req_dest[s*L +: L]),
            .win       (win[s]),
            .trying    (trying[s]),
            .hold      (hold[s]),
            .denied    (denied[s]),
            .held_dest (held_dest[s*L +: L])
        );
        assign ln_src[0][s*L +: L] = L'(s);
    end

    assign ln_vld[0] = trying;
    assign ln_tag[0] = req_dest;

    omega_occupancy #(.L(L)) u_occ (
        .hold      (hold),
        .held_dest (held_dest),
        .busy      (busy)
    );

    for (genvar k = 0; k < L; k++) begin : g_stage
        omega_stage #(.L(L), .K(k)) u_stg (
            .in_vld  (ln_vld[k]),
            .in_src  (ln_src[k]),
            .in_tag  (ln_tag[k]),
            .busy    (busy[k*N +: N]),
            .out_vld (ln_vld[k+1]),
            .out_src (ln_src[k+1]),
            .out_tag (ln_tag[k+1])
        );
    end

    // A source wins setup when its request reaches its destination line.
    always_comb begin
        win = '0;
        for (int s = 0; s < N; s++) begin
            for (int d = 0; d < N; d++) begin
                if (ln_vld[L][d] && ln_src[L][d*L +: L] == L'(s)
                                 && ln_tag[L][d*L +: L] == L'(d))
                    win[s] = 1'b1;
            end
        end
    end

    // Data path over locked connections.
    always_comb begin
        dst_valid = '0;
        dst_src   = '0;
        dst_data  = '0;
        for (int d = 0; d < N; d++) begin
            for (int s = 0; s < N; s++) begin
                if (hold[s] && held_dest[s*L +: L] == L'(d)) begin
                    dst_valid[d]          = 1'b1;
                    dst_src[d*L +: L]     = L'(s);
                    dst_data[d*DW +: DW]  = req_data[s*DW +: DW];
                end
            end
        end
    end

    assign src_granted = hold;
    assign src_blocked = denied;
endmodule

// File: rtl/omega_router_chk.sv
`timescale 1ns/1ps
module omega_router_chk #(
    parameter int LOG2N = 3,
    parameter int DW    = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [(1<<LOG2N)-1:0]       req_valid,
    input logic [(1<<LOG2N)-1:0]       src_granted,
    input logic [(1<<LOG2N)-1:0]       src_blocked,
    input logic [(1<<LOG2N)-1:0]       dst_valid,
    input logic [(1<<LOG2N)*LOG2N-1:0] dst_src
);
    localparam int L = LOG2N;
    localparam int N = 1 << L;

    p_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(src_granted) == $countones(dst_valid));

    for (genvar s = 0; s < N; s++) begin : g_s
        p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !req_valid[s] |=> (!src_granted[s] && !src_blocked[s]));
        p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (src_granted[s] && req_valid[s]) |=> src_granted[s]);
        p_stuck_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (src_blocked[s] && req_valid[s]) |=> src_blocked[s]);
        p_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !(src_granted[s] && src_blocked[s]));
        p_setup_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (!src_granted[s] && !src_blocked[s] && !req_valid[s]) |=> !src_granted[s]);
    end

    for (genvar a = 0; a < N; a++) begin : g_a
        for (genvar b = a + 1; b < N; b++) begin : g_b
            p_unique_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (dst_valid[a] && dst_valid[b]) |-> (dst_src[a*L +: L] != dst_src[b*L +: L]));
        end
    end
endmodule

bind omega_router omega_router_chk #(.LOG2N(LOG2N), .DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .src_granted (src_granted),
    .src_blocked (src_blocked),
    .dst_valid   (dst_valid),
    .dst_src     (dst_src)
);

// File: tb/omega_router_bench.sv
`timescale 1ns/1ps
module omega_router_bench;
    localparam int L  = 3;
    localparam int N  = 8;
    localparam int DW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [N-1:0]    req_valid = '0;
    logic [N*L-1:0]  req_dest = '0;
    logic [N*DW-1:0] req_data = '0;
    logic [N-1:0]    src_granted, src_blocked, dst_valid;
    logic [N*L-1:0]  dst_src;
    logic [N*DW-1:0] dst_data;

    omega_router #(.LOG2N(L), .DW(DW)) u_omega_router (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dest(req_dest),
        .req_data(req_data), .src_granted(src_granted), .src_blocked(src_blocked),
        .dst_valid(dst_valid), .dst_src(dst_src), .dst_data(dst_data)
    );

    int checks = 0;
    int failures = 0;
    int b_vld[N], b_dest[N], b_data[N];
    int e_st[N], e_dest[N];   // 0 idle, 1 held, 2 denied
    int seed = 32'h1d3a;

    function automatic int rl(input int v);
        return ((v << 1) | (v >> (L - 1))) & (N - 1);
    endfunction
    function automatic int lineafter(input int s, input int d, input int k);
        return ((s << (k + 1)) & (N - 1)) | (d >> (L - 1 - k));
    endfunction
    function automatic int rnd();
        seed = seed * 1103515245 + 12345;
        return (seed >>> 8) & 32'h7fff;
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        int gv, bv, owner;
        gv = 0; bv = 0;
        for (int s = 0; s < N; s++) begin
            if (e_st[s] == 1) gv |= (1 << s);
            if (e_st[s] == 2) bv |= (1 << s);
        end
        chk(tag, "src_granted", int'(src_granted), gv);
        chk(tag, "src_blocked", int'(src_blocked), bv);
        for (int d = 0; d < N; d++) begin
            owner = -1;
            for (int s = 0; s < N; s++) if (e_st[s] == 1 && e_dest[s] == d) owner = s;
            chk(tag, $sformatf("dst_valid[%0d]", d), int'(dst_valid[d]), owner >= 0);
            if (owner >= 0) begin
                chk(tag, $sformatf("dst_src[%0d]", d), int'(dst_src[d*L +: L]), owner);
                chk(tag, $sformatf("dst_data[%0d]", d), int'(dst_data[d*DW +: DW]), b_data[owner]);
            end
        end
    endtask

    // Drive the b_* arrays for one cycle, advance the expected model, compare.
    task automatic step(input string tag);
        int alive[N], nalive[N], prev[N], port[N], ol[N];
        @(negedge clk);
        for (int s = 0; s < N; s++) begin
            req_valid[s] = b_vld[s] != 0;
            req_dest[s*L +: L] = L'(b_dest[s]);
            req_data[s*DW +: DW] = DW'(b_data[s]);
            alive[s] = (e_st[s] == 0 && b_vld[s] != 0);
            prev[s] = s;
        end
        for (int k = 0; k < L; k++) begin
            for (int s = 0; s < N; s++) begin
                port[s] = rl(prev[s]) & 1;
                ol[s] = lineafter(s, b_dest[s], k);
            end
            for (int s = 0; s < N; s++) begin
                nalive[s] = alive[s];
                if (alive[s]) begin
                    for (int t = 0; t < N; t++) begin
                        if (e_st[t] == 1 && lineafter(t, e_dest[t], k) == ol[s]) nalive[s] = 0;
                        if (t != s && alive[t] && ol[t] == ol[s] && port[t] == 0 && port[s] == 1)
                            nalive[s] = 0;
                    end
                end
            end
            for (int s = 0; s < N; s++) begin
                alive[s] = nalive[s];
                prev[s] = ol[s];
            end
        end
        for (int s = 0; s < N; s++) begin
            if (b_vld[s] == 0) e_st[s] = 0;
            else if (e_st[s] == 0) begin
                e_st[s] = alive[s] ? 1 : 2;
                if (alive[s]) e_dest[s] = b_dest[s];
            end
        end
        @(posedge clk);
        #1;
        compare(tag);
    endtask

    task automatic all_off();
        for (int s = 0; s < N; s++) b_vld[s] = 0;
    endtask

    initial begin
        #1000000;
        failures++;
        $display("FAIL watchdog expired (all requirements) actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int s = 0; s < N; s++) begin
            b_vld[s] = 0; b_dest[s] = 0; b_data[s] = 0; e_st[s] = 0; e_dest[s] = 0;
        end
        // R9: outputs zero in reset
        repeat (3) @(posedge clk);
        #1;
        compare("R9");
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        compare("R9");

        // R1: every single source/destination pair
        for (int s = 0; s < N; s++) begin
            for (int d = 0; d < N; d++) begin
                b_vld[s] = 1; b_dest[s] = d; b_data[s] = (s * 16 + d) & 255;
                step("R1");
                b_vld[s] = 0;
                step("R7");
            end
        end

        // R2/R3/R8: all two-source destination combinations
        for (int s1 = 0; s1 < N; s1++) begin
            for (int s2 = s1 + 1; s2 < N; s2++) begin
                for (int d1 = 0; d1 < N; d1++) begin
                    for (int d2 = 0; d2 < N; d2++) begin
                        b_vld[s1] = 1; b_dest[s1] = d1; b_data[s1] = rnd() & 255;
                        b_vld[s2] = 1; b_dest[s2] = d2; b_data[s2] = rnd() & 255;
                        step("R2/R3/R8");
                        all_off();
                        step("R7");
                    end
                end
            end
        end

        // R3: sources 0 and 4 toward the upper destinations
        b_vld[0] = 1; b_dest[0] = 5; b_data[0] = 8'h11;
        b_vld[4] = 1; b_dest[4] = 6; b_data[4] = 8'h44;
        step("R3");
        chk("R3", "upper source 0 granted", int'(src_granted[0]), 1);
        chk("R3", "lower source 4 blocked", int'(src_blocked[4]), 1);
        all_off();
        step("R7");

        // R6/R5/R4/R7: lock held by source 4, upper source 0 then asks
        b_vld[4] = 1; b_dest[4] = 4; b_data[4] = 8'h5a;
        step("R1");
        b_vld[0] = 1; b_dest[0] = 5; b_data[0] = 8'h33;
        step("R6");
        chk("R6", "source 0 blocked by lock", int'(src_blocked[0]), 1);
        chk("R6", "source 4 still granted", int'(src_granted[4]), 1);
        b_dest[4] = 1; b_data[4] = 8'hc3;
        step("R5");
        chk("R5", "dst 4 follows new data", int'(dst_data[4*DW +: DW]), 8'hc3);
        chk("R5", "dst 1 untouched by tag change", int'(dst_valid[1]), 0);
        b_vld[4] = 0;
        step("R7");
        chk("R7", "dst 4 released", int'(dst_valid[4]), 0);
        step("R4");
        chk("R4", "source 0 stays blocked", int'(src_blocked[0]), 1);
        b_vld[0] = 0;
        step("R7");
        b_vld[0] = 1;
        step("R7");
        chk("R7", "source 0 granted on retry", int'(src_granted[0]), 1);
        all_off();
        step("R7");

        // R2/R4/R5/R6/R8: random full-load traffic with locks
        for (int i = 0; i < 600; i++) begin
            for (int s = 0; s < N; s++) begin
                if ((rnd() & 3) == 0) b_vld[s] = !b_vld[s];
                b_dest[s] = rnd() & (N - 1);
                b_data[s] = rnd() & 255;
            end
            step("R2/R4/R5/R6/R8");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule